// File: doc/BRIEF.md
# Cartridge ROM/RAM Bank Controller

This block maps a 16-bit CPU address space with an 8-bit data bus onto a large external ROM and a banked external RAM. The lower quarter of the CPU space always shows the first 16 KiB of ROM. The next quarter is a window onto any of up to 128 ROM banks. An 8 KiB window at 0xA000 reaches one of up to four external RAM banks.

The ROM is read-only, so CPU writes below 0x8000 are taken as control commands. Four write regions set RAM enable, the low five ROM bank bits, a two-bit field and the banking mode. The mode decides where the two-bit field goes when it is written. In mode 0 it becomes the top ROM bank bits. In mode 1 it becomes the RAM bank number. A low bank field of zero always selects the bank just above it. RAM access is gated by the enable bit: while RAM is disabled, reads return 0xFF and writes never reach the chip.

Address translation is combinational from the current register state. A control write takes effect at the next rising clock edge.

Top module: `bank_ctrl`

## Requirements
- R1: After reset the switchable ROM window uses bank 1, the banking mode is 0 and RAM is disabled. A read at 0x4000 therefore gives romAddr 0x04000, and a read at 0xA000 gives ramCs low and read data 0xFF.
- R2: A read at CPU address 0x0000–0x3FFF asserts romCs and drives romAddr equal to the CPU address, whatever the bank registers hold. cpuRdData then equals romRdData.
- R3: A read at CPU address 0x4000–0x7FFF asserts romCs and drives romAddr = effective bank × 0x4000 + (address − 0x4000). The effective bank is {two-bit ROM field, five-bit low field}. cpuRdData then equals romRdData.
- R4: A write anywhere in 0x0000–0x1FFF enables RAM if data[3:0] is 0xA, and disables it for any other value. Data bits [7:4] are ignored.
- R5: A write in 0x2000–0x3FFF loads the low ROM bank field from data[4:0]. It leaves the upper ROM bank bits unchanged.
- R6: A write in 0x4000–0x5FFF takes data[1:0]. In mode 0 they become ROM bank bits [6:5] and the RAM bank is unchanged. In mode 1 they become the RAM bank and the ROM bank is unchanged.
- R7: A write in 0x6000–0x7FFF sets the banking mode to data[0]. The other data bits are ignored.
- R8: When the low ROM bank field is 0, the switchable window uses low field 1 instead. Banks 0x00, 0x20, 0x40 and 0x60 therefore become 0x01, 0x21, 0x41 and 0x61.
- R9: While RAM is enabled, a read or write at 0xA000–0xBFFF asserts ramCs and drives ramAddr = bank × 0x2000 + (address − 0xA000). The bank is 0 in mode 0 and the RAM bank register in mode 1. A write also asserts ramWe with ramWrData equal to cpuWrData. A read returns ramRdData.
- R10: While RAM is disabled, accesses at 0xA000–0xBFFF keep ramCs and ramWe low, and reads return 0xFF.
- R11: Reads at 0x8000–0x9FFF and 0xC000–0xFFFF assert neither chip select and return 0xFF. Writes below 0x8000 never assert romCs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuAddr | input | 16 | CPU address |
| cpuWrData | input | 8 | CPU write data |
| cpuWr | input | 1 | CPU write strobe for this cycle |
| cpuRd | input | 1 | CPU read strobe for this cycle |
| cpuRdData | output | 8 | Read data returned to the CPU |
| romAddr | output | 21 | Physical ROM byte address |
| romCs | output | 1 | ROM chip select |
| romRdData | input | 8 | Data from the ROM |
| ramAddr | output | 15 | Physical RAM byte address |
| ramCs | output | 1 | RAM chip enable |
| ramWe | output | 1 | RAM write enable |
| ramWrData | output | 8 | Data to the RAM |
| ramRdData | input | 8 | Data from the RAM |

## Verification
Chip selects, physical addresses and read data depend combinationally on the inputs in the same cycle. The bench drives each access at a falling edge and compares its result 1 ns later, before the next rising edge. A control write changes the outputs from the following cycle on. The reference model in the bench therefore updates its state only after it has queued the expected item for the write cycle. The next access, one falling edge later, is checked against the new state.

// File: rtl/bank_ctrl_pkg.sv
`timescale 1ns/1ps
package bank_ctrl_pkg;

  // Strobes from the decoder to the register/datapath
  typedef struct packed {
    logic ramEnWr;   // write to RAM-enable region
    logic lowWr;     // write to low ROM bank field
    logic pairWr;    // write to the shared two-bit field
    logic modeWr;    // write to banking mode
    logic romFixRd;  // read of fixed ROM bank
    logic romSwRd;   // read of switchable ROM window
    logic ramRd;     // read in RAM window
    logic ramWr;     // write in RAM window
  } ctrlStrobe_t;

  localparam logic [1:0] REGION_RAMEN = 2'd0;
  localparam logic [1:0] REGION_LOW   = 2'd1;
  localparam logic [1:0] REGION_PAIR  = 2'd2;
  localparam logic [1:0] REGION_MODE  = 2'd3;

  localparam logic [3:0] RAM_KEY = 4'hA;

endpackage

// File: rtl/bank_ctrl_decode.sv
`timescale 1ns/1ps
module bank_ctrl_decode
  import bank_ctrl_pkg::*;
(
  input  logic [15:0]  cpuAddr,
  input  logic         cpuWr,
  input  logic         cpuRd,
  output ctrlStrobe_t  strobe
);

  logic       inRomSpace;
  logic       inFixedRom;
  logic       inSwitchRom;
  logic       inRamWindow;
  logic [1:0] region;

  always_comb begin
    inRomSpace  = ~cpuAddr[15];
    inFixedRom  = (cpuAddr[15:14] == 2'b00);
    inSwitchRom = (cpuAddr[15:14] == 2'b01);
    inRamWindow = (cpuAddr[15:13] == 3'b101);
    region      = cpuAddr[14:13];
  end

  always_comb begin
    strobe          = '0;
    strobe.romFixRd = cpuRd & inFixedRom;
    strobe.romSwRd  = cpuRd & inSwitchRom;
    strobe.ramRd    = cpuRd & inRamWindow;
    strobe.ramWr    = cpuWr & inRamWindow;
    if (cpuWr && inRomSpace) begin
      unique case (region)
        REGION_RAMEN: strobe.ramEnWr = 1'b1;
        REGION_LOW:   strobe.lowWr   = 1'b1;
        REGION_PAIR:  strobe.pairWr  = 1'b1;
        REGION_MODE:  strobe.modeWr  = 1'b1;
        default:      strobe         = strobe;
      endcase
    end
  end

endmodule

// File: rtl/bank_zero_fix.sv
`timescale 1ns/1ps
module bank_zero_fix #(
  parameter int WIDTH = 5
) (
  input  logic [WIDTH-1:0] rawLow,
  output logic [WIDTH-1:0] effLow
);

  logic isZero;

  generate
    if (WIDTH == 1) begin : g_single
      always_comb begin
        isZero = ~rawLow[0];
        effLow = 1'b1;
      end
    end else begin : g_multi
      always_comb begin
        isZero = (rawLow == '0);
        effLow = {rawLow[WIDTH-1:1], rawLow[0] | isZero};
      end
    end
  endgenerate

endmodule

// File: rtl/bank_ctrl_path.sv
`timescale 1ns/1ps
module bank_ctrl_path
  import bank_ctrl_pkg::*;
#(
  parameter int LOW_BITS     = 5,
  parameter int PAIR_BITS    = 2,
  parameter int ROM_OFS_BITS = 14,
  parameter int RAM_OFS_BITS = 13,
  localparam int BANK_BITS   = LOW_BITS + PAIR_BITS,
  localparam int ROM_AW      = BANK_BITS + ROM_OFS_BITS,
  localparam int RAM_AW      = PAIR_BITS + RAM_OFS_BITS
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctrlStrobe_t             strobe,
  input  logic [ROM_OFS_BITS-1:0] cpuOfs,
  input  logic [7:0]              wrData,
  input  logic [7:0]              romRdData,
  input  logic [7:0]              ramRdData,
  output logic [7:0]              cpuRdData,
  output logic [ROM_AW-1:0]       romAddr,
  output logic                    romCs,
  output logic [RAM_AW-1:0]       ramAddr,
  output logic                    ramCs,
  output logic                    ramWe,
  output logic [7:0]              ramWrData
);

  logic                 ramEnQ;
  logic                 modeQ;
  logic [LOW_BITS-1:0]  lowQ;
  logic [PAIR_BITS-1:0] romHighQ;
  logic [PAIR_BITS-1:0] ramBankQ;
  logic [LOW_BITS-1:0]  effLow;
  logic [PAIR_BITS-1:0] ramBankSel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ramEnQ   <= 1'b0;
      modeQ    <= 1'b0;
      lowQ     <= LOW_BITS'(1);
      romHighQ <= '0;
      ramBankQ <= '0;
    end else begin
      if (strobe.ramEnWr) ramEnQ <= (wrData[3:0] == RAM_KEY);
      if (strobe.lowWr)   lowQ   <= wrData[LOW_BITS-1:0];
      if (strobe.modeWr)  modeQ  <= wrData[0];
      if (strobe.pairWr) begin
        if (modeQ) ramBankQ <= wrData[PAIR_BITS-1:0];
        else       romHighQ <= wrData[PAIR_BITS-1:0];
      end
    end
  end

  bank_zero_fix #(.WIDTH(LOW_BITS)) zeroFixI (
    .rawLow (lowQ),
    .effLow (effLow)
  );

  always_comb begin
    romCs = strobe.romFixRd | strobe.romSwRd;
    if (strobe.romSwRd) romAddr = {romHighQ, effLow, cpuOfs};
    else                romAddr = {{BANK_BITS{1'b0}}, cpuOfs};
  end

  always_comb begin
    ramBankSel = modeQ ? ramBankQ : '0;
    ramAddr    = {ramBankSel, cpuOfs[RAM_OFS_BITS-1:0]};
    ramCs      = ramEnQ & (strobe.ramRd | strobe.ramWr);
    ramWe      = ramEnQ & strobe.ramWr;
    ramWrData  = wrData;
  end

  always_comb begin
    if (romCs)                        cpuRdData = romRdData;
    else if (ramEnQ && strobe.ramRd)  cpuRdData = ramRdData;
    else                              cpuRdData = 8'hFF;
  end

endmodule

// File: rtl/bank_ctrl.sv
`timescale 1ns/1ps
module bank_ctrl
  import bank_ctrl_pkg::*;
#(
  parameter int LOW_BITS     = 5,
  parameter int PAIR_BITS    = 2,
  parameter int ROM_OFS_BITS = 14,
  parameter int RAM_OFS_BITS = 13,
  localparam int ROM_AW      = LOW_BITS + PAIR_BITS + ROM_OFS_BITS,
  localparam int RAM_AW      = PAIR_BITS + RAM_OFS_BITS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [15:0]       cpuAddr,
  input  logic [7:0]        cpuWrData,
  input  logic              cpuWr,
  input  logic              cpuRd,
  output logic [7:0]        cpuRdData,
  output logic [ROM_AW-1:0] romAddr,
  output logic              romCs,
  input  logic [7:0]        romRdData,
  output logic [RAM_AW-1:0] ramAddr,
  output logic              ramCs,
  output logic              ramWe,
  output logic [7:0]        ramWrData,
  input  logic [7:0]        ramRdData
);

  ctrlStrobe_t strobe;

  bank_ctrl_decode decodeI (
    .cpuAddr (cpuAddr),
    .cpuWr   (cpuWr),
    .cpuRd   (cpuRd),
    .strobe  (strobe)
  );

  bank_ctrl_path #(
    .LOW_BITS     (LOW_BITS),
    .PAIR_BITS    (PAIR_BITS),
    .ROM_OFS_BITS (ROM_OFS_BITS),
    .RAM_OFS_BITS (RAM_OFS_BITS)
  ) pathI (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .cpuOfs    (cpuAddr[ROM_OFS_BITS-1:0]),
    .wrData    (cpuWrData),
    .romRdData (romRdData),
    .ramRdData (ramRdData),
    .cpuRdData (cpuRdData),
    .romAddr   (romAddr),
    .romCs     (romCs),
    .ramAddr   (ramAddr),
    .ramCs     (ramCs),
    .ramWe     (ramWe),
    .ramWrData (ramWrData)
  );

endmodule

// File: rtl/bank_ctrl_chk.sv
`timescale 1ns/1ps
module bank_ctrl_chk #(
  parameter int ROM_AW       = 21,
  parameter int RAM_AW       = 15,
  parameter int ROM_OFS_BITS = 14,
  parameter int RAM_OFS_BITS = 13,
  parameter int LOW_BITS     = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic [15:0]       cpuAddr,
  input logic [7:0]        cpuWrData,
  input logic              cpuWr,
  input logic              cpuRd,
  input logic [7:0]        cpuRdData,
  input logic [ROM_AW-1:0] romAddr,
  input logic              romCs,
  input logic [RAM_AW-1:0] ramAddr,
  input logic              ramCs,
  input logic              ramWe
);

  logic keyWrite;
  logic badKeyWrite;
  logic mode0Write;
  logic ramWinAcc;

  always_comb begin
    keyWrite    = cpuWr && cpuAddr[15:13] == 3'b000 && cpuWrData[3:0] == 4'hA;
    badKeyWrite = cpuWr && cpuAddr[15:13] == 3'b000 && cpuWrData[3:0] != 4'hA;
    mode0Write  = cpuWr && cpuAddr[15:13] == 3'b011 && !cpuWrData[0];
    ramWinAcc   = (cpuRd || cpuWr) && cpuAddr[15:13] == 3'b101;
  end

  AST_FIXED_BANK_DIRECT: assert property (@(posedge clk) disable iff (!rstN)
    (cpuRd && cpuAddr[15:14] == 2'b00) |->
      (romCs && romAddr[ROM_AW-1:ROM_OFS_BITS] == '0 &&
       romAddr[ROM_OFS_BITS-1:0] == cpuAddr[ROM_OFS_BITS-1:0])); // R2

  AST_LOW_NEVER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (romCs && cpuAddr[15:14] == 2'b01) |->
      romAddr[ROM_OFS_BITS+LOW_BITS-1:ROM_OFS_BITS] != '0); // R8

  AST_KEY_ENABLES: assert property (@(posedge clk) disable iff (!rstN)
    ($past(keyWrite) && cpuRd && cpuAddr[15:13] == 3'b101) |-> ramCs); // R4

  AST_BAD_KEY_DISABLES: assert property (@(posedge clk) disable iff (!rstN)
    $past(badKeyWrite) |-> (!ramCs && !ramWe)); // R10

  AST_MODE0_BANK_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    ($past(mode0Write) && ramCs) |-> ramAddr[RAM_AW-1:RAM_OFS_BITS] == '0); // R9

  AST_WE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> (ramCs && cpuWr)); // R9

  AST_NO_STRAY_SELECT: assert property (@(posedge clk) disable iff (!rstN)
    (cpuRd && !cpuWr && cpuAddr[15] && !ramWinAcc) |->
      (!romCs && !ramCs && cpuRdData == 8'hFF)); // R11

endmodule

bind bank_ctrl bank_ctrl_chk #(
  .ROM_AW       (ROM_AW),
  .RAM_AW       (RAM_AW),
  .ROM_OFS_BITS (ROM_OFS_BITS),
  .RAM_OFS_BITS (RAM_OFS_BITS),
  .LOW_BITS     (LOW_BITS)
) chkI (
  .clk       (clk),
  .rstN      (rstN),
  .cpuAddr   (cpuAddr),
  .cpuWrData (cpuWrData),
  .cpuWr     (cpuWr),
  .cpuRd     (cpuRd),
  .cpuRdData (cpuRdData),
  .romAddr   (romAddr),
  .romCs     (romCs),
  .ramAddr   (ramAddr),
  .ramCs     (ramCs),
  .ramWe     (ramWe)
);

// File: tb/bank_ctrl_tb_top.sv
`timescale 1ns/1ps
module bank_ctrl_tb_top;

  typedef struct {
    logic [20:0] romA;
    logic        romC;
    logic [14:0] ramA;
    logic        ramC;
    logic        ramW;
    logic        rd;
    logic [7:0]  data;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic [7:0]  cpuWrData = '0;
  logic        cpuWr = 1'b0;
  logic        cpuRd = 1'b0;
  logic [7:0]  cpuRdData;
  logic [20:0] romAddr;
  logic        romCs;
  logic [7:0]  romRdData;
  logic [14:0] ramAddr;
  logic        ramCs;
  logic        ramWe;
  logic [7:0]  ramWrData;
  logic [7:0]  ramRdData;

  int nChecks = 0;
  int nErrors = 0;
  bit finished = 0;
  exp_t expQ[$];

  // reference model state
  logic       mRamEn = 1'b0;
  logic       mMode  = 1'b0;
  logic [4:0] mLow   = 5'd1;
  logic [1:0] mHigh  = 2'd0;
  logic [1:0] mRamBank = 2'd0;

  always #2 clk = ~clk;

  function automatic logic [7:0] romByte(logic [20:0] a);
    return a[7:0] ^ a[20:13];
  endfunction

  function automatic logic [7:0] ramByte(logic [14:0] a);
    return a[7:0] ^ {1'b0, a[14:8]};
  endfunction

  assign romRdData = romByte(romAddr);
  assign ramRdData = ramByte(ramAddr);

  bank_ctrl dut_i (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuWrData(cpuWrData),
    .cpuWr(cpuWr), .cpuRd(cpuRd), .cpuRdData(cpuRdData),
    .romAddr(romAddr), .romCs(romCs), .romRdData(romRdData),
    .ramAddr(ramAddr), .ramCs(ramCs), .ramWe(ramWe),
    .ramWrData(ramWrData), .ramRdData(ramRdData)
  );

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  endtask

  // driver: one access per call, expected item from the model
  task automatic access(logic [15:0] a, bit wr, logic [7:0] d, string tag);
    exp_t e;
    logic [4:0] effLow;
    @(negedge clk);
    cpuAddr = a; cpuWr = wr; cpuRd = !wr; cpuWrData = d;
    effLow = (mLow == 5'd0) ? 5'd1 : mLow;
    e.romA = '0; e.romC = 0; e.ramA = '0; e.ramC = 0; e.ramW = 0;
    e.rd = !wr; e.data = 8'hFF; e.tag = tag;
    if (!wr && a[15:14] == 2'b00) begin
      e.romC = 1; e.romA = {7'd0, a[13:0]}; e.data = romByte(e.romA);
    end else if (!wr && a[15:14] == 2'b01) begin
      e.romC = 1; e.romA = {mHigh, effLow, a[13:0]}; e.data = romByte(e.romA);
    end else if (a[15:13] == 3'b101 && mRamEn) begin
      e.ramC = 1; e.ramW = wr;
      e.ramA = {(mMode ? mRamBank : 2'd0), a[12:0]};
      if (!wr) e.data = ramByte(e.ramA);
    end
    expQ.push_back(e);
    if (wr && !a[15]) begin
      case (a[14:13])
        2'd0: mRamEn = (d[3:0] == 4'hA);
        2'd1: mLow = d[4:0];
        2'd2: if (mMode) mRamBank = d[1:0]; else mHigh = d[1:0];
        default: mMode = d[0];
      endcase
    end
  endtask

  task automatic rd(logic [15:0] a, string tag);
    access(a, 0, 8'h00, tag);
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d, string tag);
    access(a, 1, d, tag);
  endtask

  // monitor: compare 1 ns after the driving edge
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      #1;
      if (expQ.size() > 0) begin
        e = expQ.pop_front();
        check(e.tag, "romCs", romCs, e.romC);
        check(e.tag, "ramCs", ramCs, e.ramC);
        check(e.tag, "ramWe", ramWe, e.ramW);
        if (e.romC) check(e.tag, "romAddr", romAddr, e.romA);
        if (e.ramC) check(e.tag, "ramAddr", ramAddr, e.ramA);
        if (e.ramW) check(e.tag, "ramWrData", ramWrData, cpuWrData);
        if (e.rd)   check(e.tag, "cpuRdData", cpuRdData, e.data);
      end
    end
  end

  initial begin
    #400000;
    nErrors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    rd(16'h4000, "R1");
    rd(16'hA000, "R1");
    wr(16'hA000, 8'h55, "R10");
    // R2: fixed bank direct
    rd(16'h0000, "R2");
    rd(16'h3FFF, "R2");
    rd(16'h1234, "R2");
    // R5 / R3: low field
    wr(16'h2000, 8'hFF, "R5");
    rd(16'h7FFF, "R3");
    rd(16'h0ABC, "R2");
    // R6 mode 0: upper ROM bits
    wr(16'h4000, 8'hFF, "R6");
    rd(16'h4001, "R6");
    wr(16'h3FFF, 8'hE5, "R5");
    rd(16'h5555, "R5");
    // R8: zero low field remap, each upper value
    for (int u = 0; u < 4; u++) begin
      wr(16'h4000, 8'(u), "R8");
      wr(16'h2000, 8'hE0, "R8");
      rd(16'h4000, "R8");
      rd(16'h7ABC, "R8");
    end
    wr(16'h2000, 8'h01, "R8");
    rd(16'h4000, "R8");
    // R4 / R9: enable and RAM access in mode 0
    wr(16'h0000, 8'h0A, "R4");
    wr(16'hA005, 8'h3C, "R9");
    rd(16'hBFFF, "R9");
    wr(16'h1FFF, 8'h1A, "R4");
    rd(16'hA005, "R4");
    wr(16'h1000, 8'h0B, "R4");
    rd(16'hA005, "R10");
    wr(16'hB000, 8'h77, "R10");
    wr(16'h1000, 8'hFA, "R4");
    rd(16'hA100, "R4");
    // R7 / R6 mode 1: RAM bank
    wr(16'h6000, 8'h01, "R7");
    wr(16'h4000, 8'h02, "R6");
    rd(16'hA123, "R6");
    rd(16'h4000, "R6");
    wr(16'hB456, 8'h99, "R9");
    wr(16'h2000, 8'h00, "R8");
    rd(16'h6000, "R8");
    wr(16'h7FFF, 8'hFE, "R7");
    rd(16'hA123, "R7");
    wr(16'h4000, 8'h01, "R6");
    rd(16'h4000, "R6");
    wr(16'h6000, 8'h01, "R7");
    rd(16'hA123, "R6");
    // R11: unmapped reads
    rd(16'h8000, "R11");
    rd(16'h9FFF, "R11");
    rd(16'hC000, "R11");
    rd(16'hFFFF, "R11");
    wr(16'h2000, 8'h03, "R11");
    // R10 after disable in mode 1
    wr(16'h0000, 8'h00, "R10");
    rd(16'hA123, "R10");
    @(negedge clk);
    cpuRd = 0; cpuWr = 0;
    repeat (3) @(negedge clk);
    summary();
  end

endmodule